// File: doc/BRIEF.md
# Vertical-Retrace Bias Calibration Sequencer

This block is the timing controller for a per-frame picture-tube cutoff calibration. Once per frame, after the vertical edge, it counts horizontal sync pulses. On fixed line numbers it opens three overlapping windows. The first is a black-level force pulse sent to the colour processing stage. The second is a grid pulse that drives the cathode current up to a reference value during setup. The third is a program pulse that marks the sense window. It also reports a shared mode (open, setup or sense) and turns that mode into per-channel enables that gate the sample/hold switches of every colour channel.

Both sync inputs arrive already synchronised and edge detected, as one-cycle strobes in the system clock domain. The analog servo path lies outside this block. No data stream passes through it, so all pins are plain control pins with no handshake. All outputs come from registers and change on the clock edge that samples a sync strobe.

After reset the sequencer sits idle with a saturated count. A calibration cycle can begin only after a vertical edge. When the count reaches its end line it saturates, so stray horizontal pulses later in the frame cannot start a second cycle.

Top module: `bias_cal_seq`

## Requirements
- R1: While reset is held, and after it is released, blk_force, grid_pulse and prog_pulse are 0, cal_mode is open (2'b00) and setup_en/sample_en are all zero. Horizontal strobes that arrive before the first vertical strobe cause no output activity.
- R2: After a vertical strobe, horizontal strobes 1 through 13 cause no output activity: every output stays as in R1.
- R3: blk_force goes to 1 on the edge that samples horizontal strobe 14. It stays at 1 for exactly 7 lines and returns to 0 on the edge that samples strobe 21.
- R4: From strobe 15 up to strobe 18, cal_mode is setup (2'b01) and grid_pulse is 1. Both changes take place on the edges that sample those strobes.
- R5: From strobe 18 up to strobe 21, cal_mode is sense (2'b10), prog_pulse is 1 and grid_pulse is 0.
- R6: From strobe 21 on, all outputs are inactive and cal_mode is open. Further horizontal strobes have no effect until the next vertical strobe.
- R7: A vertical strobe at any point makes every output inactive on the next edge and restarts the count at zero. A vertical strobe has priority over a horizontal strobe sampled in the same cycle.
- R8: setup_en has all NUM_CH bits set exactly while cal_mode is setup and is zero otherwise. sample_en has all bits set exactly while cal_mode is sense and is zero otherwise.
- R9: The outputs change only on an edge that samples a sync strobe. In every other cycle they hold their values, and cal_mode never takes the value 2'b11.
- R10: grid_pulse and prog_pulse are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_edge | input | 1 | One-cycle strobe at the start of vertical blanking |
| hsync_edge | input | 1 | One-cycle strobe per horizontal sync pulse |
| blk_force | output | 1 | Forces the colour stage to black level |
| grid_pulse | output | 1 | Raises cathode current during setup |
| prog_pulse | output | 1 | Reference pulse for the sense window |
| cal_mode | output | 2 | 00 open, 01 setup, 10 sense |
| setup_en | output | NUM_CH | Per-channel setup gate |
| sample_en | output | NUM_CH | Per-channel sample gate |

## Verification
The bench builds the block with its default line schedule (14, 15, 18, 21) and three channels. Lines in the bench are only a few clocks apart, so complete frames, aborts and saturation runs fit into a few hundred cycles. With these values the bench can check every window boundary line by line, including the overlap where setup ends and sense begins. It also covers a vertical strobe that lands in the middle of the setup window and one that coincides with a horizontal strobe.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OPEN  = 2'b00,
    MODE_SETUP = 2'b01,
    MODE_SENSE = 2'b10
  } cal_mode_e;

  typedef struct packed {
    logic      force_blk;
    logic      grid;
    logic      prog;
    cal_mode_e mode;
  } win_t;

  localparam win_t WIN_IDLE = '{force_blk: 1'b0, grid: 1'b0, prog: 1'b0, mode: MODE_OPEN};

endpackage

// File: rtl/bias_line_counter.sv
module bias_line_counter #(
  parameter int END_LINE = 21,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_strobe,
  input  logic          h_strobe,
  output logic [CW-1:0] line_q,
  output logic [CW-1:0] line_d
);

  localparam logic [CW-1:0] SAT = CW'(END_LINE);

  // vertical strobe wins; count saturates at the end line
  always_comb begin
    line_d = line_q;
    if (v_strobe) begin
      line_d = '0;
    end else if (h_strobe && (line_q != SAT)) begin
      line_d = line_q + CW'(1);
    end
  end

  // idle after reset: saturated, waits for a vertical strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= SAT;
    end else begin
      line_q <= line_d;
    end
  end

endmodule

// File: rtl/bias_window_decode.sv
module bias_window_decode
  import bias_seq_pkg::*;
#(
  parameter int FORCE_LINE = 14,
  parameter int SETUP_LINE = 15,
  parameter int SENSE_LINE = 18,
  parameter int END_LINE   = 21,
  parameter int CW         = 5
) (
  input  logic [CW-1:0] line,
  output win_t          win
);

  localparam logic [CW-1:0] L_FORCE = CW'(FORCE_LINE);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_LINE);
  localparam logic [CW-1:0] L_SENSE = CW'(SENSE_LINE);
  localparam logic [CW-1:0] L_END   = CW'(END_LINE);

  logic in_force;
  logic in_setup;
  logic in_sense;

  always_comb begin
    in_force = (line >= L_FORCE) && (line < L_END);
    in_setup = (line >= L_SETUP) && (line < L_SENSE);
    in_sense = (line >= L_SENSE) && (line < L_END);

    win           = WIN_IDLE;
    win.force_blk = in_force;
    win.grid      = in_setup;
    win.prog      = in_sense;
    if (in_sense) begin
      win.mode = MODE_SENSE;
    end else if (in_setup) begin
      win.mode = MODE_SETUP;
    end else begin
      win.mode = MODE_OPEN;
    end
  end

endmodule

// File: rtl/bias_channel_gate.sv
module bias_channel_gate
  import bias_seq_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cal_mode_e         mode_d,
  output logic [NUM_CH-1:0] setup_en,
  output logic [NUM_CH-1:0] sample_en
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        setup_en[ch]  <= 1'b0;
        sample_en[ch] <= 1'b0;
      end else begin
        setup_en[ch]  <= (mode_d == MODE_SETUP);
        sample_en[ch] <= (mode_d == MODE_SENSE);
      end
    end
  end

endmodule

// File: rtl/bias_cal_seq.sv
module bias_cal_seq
  import bias_seq_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int FORCE_LINE = 14,
  parameter int SETUP_LINE = 15,
  parameter int SENSE_LINE = 18,
  parameter int END_LINE   = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_edge,
  input  logic              hsync_edge,
  output logic              blk_force,
  output logic              grid_pulse,
  output logic              prog_pulse,
  output logic [1:0]        cal_mode,
  output logic [NUM_CH-1:0] setup_en,
  output logic [NUM_CH-1:0] sample_en
);

  localparam int CW = $clog2(END_LINE + 1);

  logic [CW-1:0] line_q;
  logic [CW-1:0] line_d;
  win_t          win_d;
  win_t          win_q;

  bias_line_counter #(
    .END_LINE (END_LINE),
    .CW       (CW)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .v_strobe (vsync_edge),
    .h_strobe (hsync_edge),
    .line_q   (line_q),
    .line_d   (line_d)
  );

  // decode the count being loaded so outputs align with it
  bias_window_decode #(
    .FORCE_LINE (FORCE_LINE),
    .SETUP_LINE (SETUP_LINE),
    .SENSE_LINE (SENSE_LINE),
    .END_LINE   (END_LINE),
    .CW         (CW)
  ) u_decode (
    .line (line_d),
    .win  (win_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_IDLE;
    end else begin
      win_q <= win_d;
    end
  end

  bias_channel_gate #(
    .NUM_CH (NUM_CH)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_d    (win_d.mode),
    .setup_en  (setup_en),
    .sample_en (sample_en)
  );

  assign blk_force  = win_q.force_blk;
  assign grid_pulse = win_q.grid;
  assign prog_pulse = win_q.prog;
  assign cal_mode   = win_q.mode;

endmodule

// File: rtl/bias_cal_seq_chk.sv
module bias_cal_seq_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_edge,
  input logic              hsync_edge,
  input logic              blk_force,
  input logic              grid_pulse,
  input logic              prog_pulse,
  input logic [1:0]        cal_mode,
  input logic [NUM_CH-1:0] setup_en,
  input logic [NUM_CH-1:0] sample_en
);

  // R3: any non-open mode lies inside the black-level window
  a_r3_force_covers_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode != 2'b00) |-> blk_force);

  // R5: sense is only entered from setup (or not at all)
  a_r5_sense_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode == 2'b10 && $past(cal_mode) != 2'b10) |-> ($past(cal_mode) == 2'b01));

  // R7: vertical strobe clears everything on the next edge
  a_r7_vsync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_edge |=> (!blk_force && !grid_pulse && !prog_pulse && cal_mode == 2'b00));

  // R8: per-channel gates follow the shared mode
  a_r8_setup_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_en != '0) |-> (setup_en == {NUM_CH{1'b1}} && cal_mode == 2'b01));
  a_r8_sample_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en != '0) |-> (sample_en == {NUM_CH{1'b1}} && cal_mode == 2'b10));

  // R9: no change without a sync strobe; no illegal mode code
  a_r9_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_edge && !hsync_edge) |=> ($stable(blk_force) && $stable(grid_pulse) &&
                                      $stable(prog_pulse) && $stable(cal_mode)));
  a_r9_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode != 2'b11);

  // R10: grid and program pulses are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grid_pulse, prog_pulse}));

endmodule

bind bias_cal_seq bias_cal_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync_edge (vsync_edge),
  .hsync_edge (hsync_edge),
  .blk_force  (blk_force),
  .grid_pulse (grid_pulse),
  .prog_pulse (prog_pulse),
  .cal_mode   (cal_mode),
  .setup_en   (setup_en),
  .sample_en  (sample_en)
);

// File: tb/test_bias_cal_seq.sv
module test_bias_cal_seq;

  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           vs = 1'b0;
  logic           hs = 1'b0;
  logic           blk_force;
  logic           grid_pulse;
  logic           prog_pulse;
  logic [1:0]     cal_mode;
  logic [NCH-1:0] setup_en;
  logic [NCH-1:0] sample_en;

  int checks = 0;
  int errors = 0;
  int line_n = 21;  // bench model of the line count; idle = saturated
  bit done = 0;

  always #2.5 clk = ~clk;

  bias_cal_seq #(.NUM_CH(NCH)) i_bias_cal_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_edge (vs),
    .hsync_edge (hs),
    .blk_force  (blk_force),
    .grid_pulse (grid_pulse),
    .prog_pulse (prog_pulse),
    .cal_mode   (cal_mode),
    .setup_en   (setup_en),
    .sample_en  (sample_en)
  );

  function automatic string tag_for(int n);
    if (n < 14) return "R2";
    if (n < 15) return "R3";
    if (n < 18) return "R4";
    if (n < 21) return "R5";
    return "R6";
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (line %0d)", req, what, act, exp, line_n);
    end
  endtask

  // compare all outputs with the schedule for the model count
  task automatic check_all(string req);
    bit ef, eg, ep;
    int em;
    ef = (line_n >= 14 && line_n < 21);
    eg = (line_n >= 15 && line_n < 18);
    ep = (line_n >= 18 && line_n < 21);
    em = ep ? 2 : (eg ? 1 : 0);
    cmp(req, "blk_force", blk_force, ef);
    cmp(req, "grid_pulse", grid_pulse, eg);
    cmp(req, "prog_pulse", prog_pulse, ep);
    cmp(req, "cal_mode", cal_mode, em);
    cmp("R8", "setup_en", setup_en, eg ? 7 : 0);
    cmp("R8", "sample_en", sample_en, ep ? 7 : 0);
    cmp("R10", "grid&prog", grid_pulse & prog_pulse, 0);
  endtask

  task automatic quiet_hold(int cycles);
    logic [1:0] m0;
    logic f0;
    m0 = cal_mode;
    f0 = blk_force;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      cmp("R9", "cal_mode hold", cal_mode, m0);
      cmp("R9", "blk_force hold", blk_force, f0);
    end
  endtask

  task automatic hpulse();
    @(negedge clk) hs = 1'b1;
    @(negedge clk) hs = 1'b0;
    if (line_n < 21) line_n++;
  endtask

  task automatic vpulse();
    @(negedge clk) vs = 1'b1;
    @(negedge clk) vs = 1'b0;
    line_n = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    line_n = 21;
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic t_idle_before_vsync();
    for (int i = 0; i < 16; i++) begin
      hpulse();
      check_all("R1");
    end
  endtask

  task automatic t_full_frame();
    vpulse();
    check_all("R7");
    for (int i = 0; i < 25; i++) begin
      hpulse();
      check_all(tag_for(line_n));
      quiet_hold(2);
    end
  endtask

  task automatic t_abort_mid_setup();
    vpulse();
    for (int i = 0; i < 16; i++) hpulse();
    check_all("R4");
    vpulse();
    check_all("R7");
    for (int i = 0; i < 14; i++) hpulse();
    check_all("R3");
  endtask

  task automatic t_simultaneous();
    vpulse();
    for (int i = 0; i < 19; i++) hpulse();
    check_all("R5");
    @(negedge clk) begin vs = 1'b1; hs = 1'b1; end
    @(negedge clk) begin vs = 1'b0; hs = 1'b0; end
    line_n = 0;
    check_all("R7");
    for (int i = 0; i < 13; i++) hpulse();
    check_all("R2");
    hpulse();
    check_all("R3");
  endtask

  initial begin
    t_reset();
    t_idle_before_vsync();
    t_full_frame();
    t_full_frame();
    t_abort_mid_setup();
    t_simultaneous();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule